// File: doc/BRIEF.md
# Auto-Restart Protection Sequencer

This block is the supervisory controller of an off-line switching regulator. It watches a set of comparator flags (supply start and stop levels, two supply overvoltage levels, junction overtemperature, feedback at its overload level, and the two thresholds of an external blanking pin) and a one-millisecond tick. From these it decides when the high-voltage startup current source charges the supply capacitor, when the power switch may toggle, how fast the duty limit rises after turn-on, and when a fault stops switching and starts a new auto-restart cycle.

After turn-on the sequencer raises a soft-start level by one step per millisecond until it reaches full scale. It then enters normal operation. Overload is not acted on at once. The feedback must stay high through a fixed internal window. After that the block enables a current source that charges an external capacitor on the blanking pin, and it declares the fault only when that pin crosses its upper level while feedback is still high. Pulling the same pin below its lowest level is a user request to stop, and the restart is held off until the pin is released. Every stop records a 3-bit cause code, which is kept through the restart and cleared once normal operation is reached.

Top module: `restart_seq`

## Requirements
- R1: In reset and in the first cycle after it, hv_cell_en is 1, and sw_en, ss_level, blk_src_en and fault_code are all 0.
- R2: While charging, vcc_on_i high at a clock edge sets sw_en to 1 and hv_cell_en to 0 from that edge on, with ss_level at 0.
- R3: During soft start, ss_level rises by one at each edge where ms_tick is high and reaches SS_MS (20) after SS_MS ticks. At the next edge the block enters normal operation. In normal operation ss_level holds at SS_MS.
- R4: vcc_ovh_i high at an edge during soft start or normal operation stops switching at that edge, with fault_code 1.
- R5: vcc_ovl_i together with fb_high_i stops switching with fault_code 1 during soft start only. In normal operation the pair is ignored and switching continues.
- R6: otp_i high while switching stops switching with fault_code 2.
- R7: In normal operation, once fb_high_i has stayed high through BLANK_MS (20) ticks, blk_src_en goes to 1. blk_upper_i then stops switching with fault_code 3 if fb_high_i is still high.
- R8: A low fb_high_i cycle clears the blanking count and sets blk_src_en to 0 at the next edge. blk_upper_i has no effect before the blanking window completes.
- R9: vcc_uv_i high while switching stops switching with fault_code 4.
- R10: blk_dis_i high while switching stops switching with fault_code 5. While blk_dis_i stays high, the block stays stopped with both hv_cell_en and sw_en at 0, even if vcc_uv_i is high.
- R11: In the stopped state, hv_cell_en and sw_en are 0. The block returns to charging (hv_cell_en 1) at the edge where vcc_uv_i is high and blk_dis_i is low. fault_code keeps its value through charging and soft start and becomes 0 on entry to normal operation.
- R12: When several causes are present at the same edge, the code follows the priority overvoltage (1) > overtemperature (2) > user request (5) > undervoltage (4) > overload (3).
- R13: While charging, every fault flag is ignored: hv_cell_en stays 1 and fault_code keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| vcc_on_i | input | 1 | Supply above turn-on level |
| vcc_uv_i | input | 1 | Supply below turn-off level |
| vcc_ovh_i | input | 1 | Supply above upper overvoltage level |
| vcc_ovl_i | input | 1 | Supply above lower overvoltage level |
| otp_i | input | 1 | Junction overtemperature |
| fb_high_i | input | 1 | Feedback above overload level |
| blk_upper_i | input | 1 | Blanking pin above upper level |
| blk_dis_i | input | 1 | Blanking pin below disable level |
| hv_cell_en | output | 1 | Startup current source enable |
| sw_en | output | 1 | Power switching enable |
| ss_level | output | SS_W | Soft-start duty limit step |
| blk_src_en | output | 1 | Blanking-pin charge current enable |
| fault_code | output | 3 | Cause of most recent stop |

## Verification
Several stop causes can arrive at the same clock edge. For example, undervoltage can coincide with a user stop request, or overvoltage with overtemperature. The bench applies such flag pairs in one cycle of normal operation and checks that exactly the higher-priority code is recorded while switching drops. The overload trip can also fall in the same cycle as another cause. The bench drives the blanking pin's upper flag at the first cycle after the window completes, and separately a cycle earlier, where the flag must be ignored.

// File: rtl/restart_seq_pkg.sv
package restart_seq_pkg;
  typedef enum logic [1:0] {
    ST_CHARGE = 2'd0,
    ST_SOFT   = 2'd1,
    ST_RUN    = 2'd2,
    ST_STOP   = 2'd3
  } rs_state_t;

  localparam logic [2:0] FC_NONE = 3'd0;
  localparam logic [2:0] FC_OVP  = 3'd1;
  localparam logic [2:0] FC_OTP  = 3'd2;
  localparam logic [2:0] FC_OLP  = 3'd3;
  localparam logic [2:0] FC_UVP  = 3'd4;
  localparam logic [2:0] FC_USER = 3'd5;
endpackage

// File: rtl/restart_seq_ramp.sv
module restart_seq_ramp #(
  parameter int SS_MS = 20,
  localparam int SS_W = $clog2(SS_MS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            adv_i,
  output logic [SS_W-1:0] level_o,
  output logic            done_o
);
  localparam logic [SS_W-1:0] TOP = SS_W'(SS_MS);

  always_ff @(posedge clk) begin
    if (rst || clr_i) level_o <= '0;
    else if (adv_i && level_o != TOP) level_o <= level_o + 1'b1;
  end

  assign done_o = (level_o == TOP);

  // R3: one step per tick while below the top
  assert_ramp_step_R3: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !clr_i && level_o != TOP) |=> level_o == $past(level_o) + 1'b1);
  assert_ramp_cap_R3: assert property (@(posedge clk) disable iff (rst)
    level_o <= TOP);
endmodule

// File: rtl/restart_seq_blank.sv
module restart_seq_blank #(
  parameter int BLANK_MS = 20,
  localparam int BW = $clog2(BLANK_MS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic tick_i,
  input  logic fb_high_i,
  input  logic upper_i,
  output logic src_en_o,
  output logic trip_o
);
  localparam logic [BW-1:0] LIMIT = BW'(BLANK_MS);
  logic [BW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !arm_i || !fb_high_i) cnt <= '0;
    else if (tick_i && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign src_en_o = (cnt == LIMIT);
  assign trip_o   = arm_i && fb_high_i && upper_i && src_en_o;

  // R8: feedback dropping ends the extension phase
  assert_blank_reset_R8: assert property (@(posedge clk) disable iff (rst)
    !fb_high_i |=> !src_en_o);
  // R7: the source only turns on at a millisecond boundary
  assert_src_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(src_en_o) |-> $past(tick_i));
endmodule

// File: rtl/restart_seq.sv
module restart_seq
  import restart_seq_pkg::*;
#(
  parameter int SS_MS    = 20,
  parameter int BLANK_MS = 20,
  localparam int SS_W    = $clog2(SS_MS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ms_tick,
  input  logic            vcc_on_i,
  input  logic            vcc_uv_i,
  input  logic            vcc_ovh_i,
  input  logic            vcc_ovl_i,
  input  logic            otp_i,
  input  logic            fb_high_i,
  input  logic            blk_upper_i,
  input  logic            blk_dis_i,
  output logic            hv_cell_en,
  output logic            sw_en,
  output logic [SS_W-1:0] ss_level,
  output logic            blk_src_en,
  output logic [2:0]      fault_code
);
  rs_state_t st, st_nx;
  logic [2:0] code_nx;
  logic       ramp_done, olp_trip;

  restart_seq_ramp #(.SS_MS(SS_MS)) u_ramp (
    .clk(clk), .rst(rst),
    .clr_i(st == ST_CHARGE || st == ST_STOP),
    .adv_i(st == ST_SOFT && ms_tick),
    .level_o(ss_level), .done_o(ramp_done));

  restart_seq_blank #(.BLANK_MS(BLANK_MS)) u_blank (
    .clk(clk), .rst(rst), .arm_i(st == ST_RUN), .tick_i(ms_tick),
    .fb_high_i(fb_high_i), .upper_i(blk_upper_i),
    .src_en_o(blk_src_en), .trip_o(olp_trip));

  always_comb begin
    st_nx   = st;
    code_nx = fault_code;
    unique case (st)
      ST_CHARGE: if (vcc_on_i) st_nx = ST_SOFT;
      ST_SOFT, ST_RUN: begin
        st_nx = ST_STOP;
        if (vcc_ovh_i || (st == ST_SOFT && vcc_ovl_i && fb_high_i)) code_nx = FC_OVP;
        else if (otp_i)     code_nx = FC_OTP;
        else if (blk_dis_i) code_nx = FC_USER;
        else if (vcc_uv_i)  code_nx = FC_UVP;
        else if (olp_trip)  code_nx = FC_OLP;
        else begin
          st_nx = st;
          if (st == ST_SOFT && ramp_done) begin
            st_nx   = ST_RUN;
            code_nx = FC_NONE;
          end
        end
      end
      ST_STOP: if (vcc_uv_i && !blk_dis_i) st_nx = ST_CHARGE;
      default: st_nx = ST_CHARGE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_CHARGE;
      fault_code <= FC_NONE;
      hv_cell_en <= 1'b1;
      sw_en      <= 1'b0;
    end else begin
      st         <= st_nx;
      fault_code <= code_nx;
      hv_cell_en <= (st_nx == ST_CHARGE);
      sw_en      <= (st_nx == ST_SOFT) || (st_nx == ST_RUN);
    end
  end

  assert_turn_on_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CHARGE && vcc_on_i) |=> (sw_en && !hv_cell_en));
  assert_ovh_stop_R4: assert property (@(posedge clk) disable iff (rst)
    (sw_en && vcc_ovh_i) |=> (!sw_en && fault_code == FC_OVP));
  assert_user_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STOP && blk_dis_i) |=> (st == ST_STOP && !hv_cell_en));
  assert_stop_cause_R11: assert property (@(posedge clk) disable iff (rst)
    (!sw_en && $past(sw_en)) |-> fault_code != FC_NONE);
  assert_charge_ignores_R13: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CHARGE && !vcc_on_i) |=> (hv_cell_en && $stable(fault_code)));
endmodule

// File: tb/restart_seq_tb.sv
`timescale 1ns/100ps
module restart_seq_tb;
  localparam int SS_MS = 20;
  localparam int BLANK_MS = 20;
  localparam int SS_W = $clog2(SS_MS + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 0, vcc_on_i = 0, vcc_uv_i = 0, vcc_ovh_i = 0, vcc_ovl_i = 0;
  logic otp_i = 0, fb_high_i = 0, blk_upper_i = 0, blk_dis_i = 0;
  logic hv_cell_en, sw_en, blk_src_en;
  logic [SS_W-1:0] ss_level;
  logic [2:0] fault_code;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  restart_seq #(.SS_MS(SS_MS), .BLANK_MS(BLANK_MS)) u_dut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .vcc_on_i(vcc_on_i),
    .vcc_uv_i(vcc_uv_i), .vcc_ovh_i(vcc_ovh_i), .vcc_ovl_i(vcc_ovl_i),
    .otp_i(otp_i), .fb_high_i(fb_high_i), .blk_upper_i(blk_upper_i),
    .blk_dis_i(blk_dis_i), .hv_cell_en(hv_cell_en), .sw_en(sw_en),
    .ss_level(ss_level), .blk_src_en(blk_src_en), .fault_code(fault_code));

  // {ovh, ovl, otp, fb, dis, uv, code[2:0]} applied for one cycle in normal operation
  localparam int NV = 9;
  localparam logic [8:0] VEC [NV] = '{
    {6'b100000, 3'd1},
    {6'b010100, 3'd0},
    {6'b001000, 3'd2},
    {6'b000010, 3'd5},
    {6'b000001, 3'd4},
    {6'b101000, 3'd1},
    {6'b001010, 3'd2},
    {6'b000011, 3'd5},
    {6'b000101, 3'd4}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  endtask

  task automatic clear_in();
    {vcc_on_i, vcc_uv_i, vcc_ovh_i, vcc_ovl_i, otp_i, fb_high_i, blk_upper_i, blk_dis_i} = '0;
    ms_tick = 1'b0;
  endtask

  task automatic to_soft();
    clear_in();
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    vcc_on_i = 1'b1;
    cyc(1);
    vcc_on_i = 1'b0;
  endtask

  task automatic to_run();
    to_soft();
    ticks(SS_MS);
    cyc(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    cyc(2);
    check("R1 cell", hv_cell_en, 1);
    check("R1 sw", sw_en, 0);
    check("R1 level", ss_level, 0);
    check("R1 code", fault_code, 0);
    check("R1 src", blk_src_en, 0);
    rst = 1'b0;
    cyc(1);
    check("R1 cell after release", hv_cell_en, 1);

    // R13 fault flags ignored while charging
    {vcc_ovh_i, otp_i, vcc_uv_i, blk_dis_i, fb_high_i} = '1;
    cyc(3);
    check("R13 cell", hv_cell_en, 1);
    check("R13 code", fault_code, 0);
    clear_in();

    // R2 / R3 turn on and ramp
    to_soft();
    check("R2 sw", sw_en, 1);
    check("R2 cell", hv_cell_en, 0);
    check("R2 level", ss_level, 0);
    ticks(5);
    check("R3 mid level", ss_level, 5);
    cyc(3);
    check("R3 no tick hold", ss_level, 5);
    ticks(SS_MS - 5);
    check("R3 full level", ss_level, SS_MS);
    cyc(1);
    ticks(4);
    check("R3 hold in run", ss_level, SS_MS);
    check("R3 still switching", sw_en, 1);

    // R12 / table: single and simultaneous causes in normal operation
    for (int v = 0; v < NV; v++) begin
      to_run();
      {vcc_ovh_i, vcc_ovl_i, otp_i, fb_high_i, blk_dis_i, vcc_uv_i} = VEC[v][8:3];
      cyc(1);
      clear_in();
      check($sformatf("R12 vector %0d code", v), fault_code, VEC[v][2:0]);
      check($sformatf("R12 vector %0d sw (R4 R5 R6 R9 R10)", v), sw_en, (VEC[v][2:0] == 0) ? 1 : 0);
    end

    // R4 overvoltage during soft start
    to_soft();
    ticks(3);
    vcc_ovh_i = 1'b1;
    cyc(1);
    clear_in();
    check("R4 soft sw", sw_en, 0);
    check("R4 soft code", fault_code, 1);

    // R5 lower overvoltage with feedback during soft start
    to_soft();
    {vcc_ovl_i, fb_high_i} = 2'b11;
    cyc(1);
    clear_in();
    check("R5 soft code", fault_code, 1);
    check("R5 soft sw", sw_en, 0);

    // R6 overtemperature during soft start
    to_soft();
    otp_i = 1'b1;
    cyc(1);
    clear_in();
    check("R6 soft code", fault_code, 2);

    // R7 / R8 overload blanking
    to_run();
    fb_high_i = 1'b1;
    ticks(BLANK_MS - 1);
    check("R8 src before window", blk_src_en, 0);
    blk_upper_i = 1'b1;
    cyc(1);
    blk_upper_i = 1'b0;
    check("R8 upper ignored early", sw_en, 1);
    check("R8 code early", fault_code, 0);
    ticks(1);
    check("R7 src on", blk_src_en, 1);
    blk_upper_i = 1'b1;
    cyc(1);
    clear_in();
    check("R7 trip sw", sw_en, 0);
    check("R7 trip code", fault_code, 3);

    // R8 feedback drop restarts window
    to_run();
    fb_high_i = 1'b1;
    ticks(10);
    fb_high_i = 1'b0;
    cyc(1);
    fb_high_i = 1'b1;
    ticks(BLANK_MS - 1);
    check("R8 restarted window", blk_src_en, 0);
    ticks(1);
    check("R8 window complete", blk_src_en, 1);
    fb_high_i = 1'b0;
    cyc(1);
    check("R8 src off after drop", blk_src_en, 0);
    check("R8 no fault", sw_en, 1);
    blk_upper_i = 1'b1;
    cyc(1);
    clear_in();
    check("R8 upper without fb", sw_en, 1);

    // R10 / R11 user hold and restart cycle
    to_run();
    blk_dis_i = 1'b1;
    cyc(1);
    check("R10 code", fault_code, 5);
    check("R10 sw", sw_en, 0);
    check("R11 cell off while stopped", hv_cell_en, 0);
    vcc_uv_i = 1'b1;
    cyc(3);
    check("R10 held cell", hv_cell_en, 0);
    check("R10 held sw", sw_en, 0);
    blk_dis_i = 1'b0;
    cyc(1);
    vcc_uv_i = 1'b0;
    check("R11 back to charging", hv_cell_en, 1);
    check("R11 code kept charging", fault_code, 5);
    vcc_on_i = 1'b1;
    cyc(1);
    vcc_on_i = 1'b0;
    check("R11 soft restart level", ss_level, 0);
    check("R11 code kept soft", fault_code, 5);
    ticks(SS_MS);
    cyc(1);
    check("R11 code cleared in run", fault_code, 0);
    check("R11 run sw", sw_en, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule